// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits between a SEC-DED encoder and the storage array on a memory write path. Encoded 72-bit codewords (64 data bits, 7 Hamming check bits, one overall parity bit at index 71) stream through it unchanged unless a control register asks for a fault. When asked, it flips one chosen bit to plant a correctable error, or flips that bit together with the overall parity bit to plant an uncorrectable one. Because the flip is applied to the encoder's finished output, the check bits written to the array are those of the clean data, and the decoder sees a real single- or double-bit event.

Each fault type can run in two ways. In continuous form it corrupts every accepted word while its enable is set. In one-shot form it corrupts only the first accepted word after the enable is set, then goes quiet. To use it again, software must write the enable to 0 and then to 1. Writing 1 over a 1 does not rearm it. The control register is loaded through a plain write-enable/data port.

The codeword path is a valid/ready stream with no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. A word counts as written only in a cycle where `in_valid` and `out_ready` are both high. While the sink holds `out_ready` low, the source must hold `in_cw` steady, and the corrupted or clean word on `out_cw` stays the same until it is accepted.

Top module: `ecc_wr_injector`

## Requirements
- R1: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` at all times. Injection state advances only on an accepted word (`in_valid && out_ready`). While a word is stalled with no register write, `out_cw` holds steady.
- R2: With no enable bit set, `out_cw` equals `in_cw`.
- R3: The control register bits are: [6:0] target position, [7] continuous single, [8] one-shot single, [9] continuous double, [10] one-shot double. A write through `reg_we`/`reg_wdata` takes effect from the next cycle. Reset clears the register.
- R4: Continuous single mode inverts the target bit of every accepted word.
- R5: One-shot single mode inverts the target bit of only the first accepted word after arming. Later words pass unchanged.
- R6: A one-shot mode rearms only after its enable has been written to 0. Rewriting 1 while the bit is already 1 does not rearm it.
- R7: Double mode inverts the target bit and bit 71. This applies to both the continuous and one-shot forms.
- R8: A position of 72 or more makes single modes inert. A position of 71 or more makes double modes inert. An inert one-shot mode is not consumed.
- R9: Among the modes able to inject, the order is continuous double, then one-shot double, then continuous single, then one-shot single. Only the chosen mode acts, and a one-shot mode that is not chosen stays armed.
- R10: At most two bits differ between `in_cw` and `out_cw`. An injected word decodes as single (R4/R5) or double (R7) under the layout above, where data bit i has the i-th non-power-of-two code from 3 upward, check bit j sits at 64+j with code 2^j, and bit 71 is even parity of bits 70:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 11 | Control register write data |
| in_valid | input | 1 | Encoded word valid |
| in_ready | output | 1 | Injector can accept the word |
| in_cw | input | 72 | Encoded codeword from the encoder |
| out_valid | output | 1 | Word valid toward the array |
| out_ready | input | 1 | Array accepts the word |
| out_cw | output | 72 | Codeword, possibly corrupted |

## Verification
The hold property assumes the source keeps `in_cw` steady while a word is stalled. The stimulus meets this by changing `in_cw` only after a word has been accepted. The one-shot property assumes the control register is not rewritten between the injecting word and the next word, so register writes in the bench fall only between writes under test. The single exception is the register-timing check, which is kept outside the window the properties watch.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int POS_W = 7;
  localparam int REG_W = POS_W + 4;
  localparam int B_CS  = POS_W;
  localparam int B_OS  = POS_W + 1;
  localparam int B_CD  = POS_W + 2;
  localparam int B_OD  = POS_W + 3;

  typedef enum logic [2:0] {
    INJ_NONE = 3'd0,
    INJ_CD   = 3'd1,
    INJ_OD   = 3'd2,
    INJ_CS   = 3'd3,
    INJ_OS   = 3'd4
  } inj_mode_e;

  typedef struct packed {
    logic             od;
    logic             cd;
    logic             os;
    logic             cs;
    logic [POS_W-1:0] pos;
  } inj_ctl_t;
endpackage

// File: rtl/inj_ctl_regs.sv
module inj_ctl_regs
  import ecc_inj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             take_od,
  input  logic             take_os,
  output inj_ctl_t         ctl_q,
  output logic             spent_od,
  output logic             spent_os
);
  localparam int N_ONCE = 2;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (reg_we) ctl_q <= inj_ctl_t'(reg_wdata);
  end

  logic [N_ONCE-1:0] take;
  logic [N_ONCE-1:0] clr;
  logic [N_ONCE-1:0] spent;

  assign take = {take_od, take_os};
  assign clr  = {reg_we & ~reg_wdata[B_OD], reg_we & ~reg_wdata[B_OS]};

  // Clearing the enable always wins over a same-cycle consumption.
  for (genvar k = 0; k < N_ONCE; k++) begin : g_once
    always_ff @(posedge clk) begin
      if (!rst_n)       spent[k] <= 1'b0;
      else if (clr[k])  spent[k] <= 1'b0;
      else if (take[k]) spent[k] <= 1'b1;
    end
  end

  assign spent_od = spent[1];
  assign spent_os = spent[0];
endmodule

// File: rtl/inj_mode_sel.sv
module inj_mode_sel
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  inj_ctl_t  ctl,
  input  logic      spent_od,
  input  logic      spent_os,
  output inj_mode_e mode
);
  localparam int SGL_LIM = CW_W;
  localparam int DBL_LIM = CW_W - 1;

  logic sgl_ok, dbl_ok;
  logic cd_go, od_go, cs_go, os_go;

  always_comb begin
    sgl_ok = 32'(ctl.pos) < SGL_LIM;
    dbl_ok = 32'(ctl.pos) < DBL_LIM;
    cd_go  = ctl.cd && dbl_ok;
    od_go  = ctl.od && !spent_od && dbl_ok;
    cs_go  = ctl.cs && sgl_ok;
    os_go  = ctl.os && !spent_os && sgl_ok;
    if (cd_go)      mode = INJ_CD;
    else if (od_go) mode = INJ_OD;
    else if (cs_go) mode = INJ_CS;
    else if (os_go) mode = INJ_OS;
    else            mode = INJ_NONE;
  end
endmodule

// File: rtl/inj_mask_gen.sv
module inj_mask_gen
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input  inj_mode_e        mode,
  input  logic [POS_W-1:0] pos,
  output logic [CW_W-1:0]  mask
);
  localparam int PAR_IDX = CW_W - 1;

  logic dbl, any;
  assign dbl = (mode == INJ_CD) || (mode == INJ_OD);
  assign any = (mode != INJ_NONE);

  for (genvar i = 0; i < CW_W; i++) begin : g_bit
    if (i == PAR_IDX) begin : g_par
      assign mask[i] = dbl || (any && (32'(pos) == i));
    end else begin : g_pos
      assign mask[i] = any && (32'(pos) == i);
    end
  end
endmodule

// File: rtl/ecc_wr_injector.sv
module ecc_wr_injector
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [REG_W-1:0]          reg_wdata,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W+CHK_W-1:0]   in_cw,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DATA_W+CHK_W-1:0]   out_cw
);
  localparam int CW_W = DATA_W + CHK_W;

  inj_ctl_t        ctl_q;
  logic            spent_od, spent_os;
  inj_mode_e       mode;
  logic [CW_W-1:0] mask;
  logic            accept;

  assign accept    = in_valid && out_ready;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  inj_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .take_od   (accept && (mode == INJ_OD)),
    .take_os   (accept && (mode == INJ_OS)),
    .ctl_q     (ctl_q),
    .spent_od  (spent_od),
    .spent_os  (spent_os)
  );

  inj_mode_sel #(.CW_W(CW_W)) u_sel (
    .ctl      (ctl_q),
    .spent_od (spent_od),
    .spent_os (spent_os),
    .mode     (mode)
  );

  inj_mask_gen #(.CW_W(CW_W)) u_mask (
    .mode (mode),
    .pos  (ctl_q.pos),
    .mask (mask)
  );

  assign out_cw = in_cw ^ mask;
endmodule

// File: rtl/inj_chk.sv
module inj_chk
  import ecc_inj_pkg::*;
#(
  parameter int CW_W = 72
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CW_W-1:0]  in_cw,
  input logic [CW_W-1:0]  out_cw,
  input logic [REG_W-1:0] ctl_q
);
  logic            live;
  logic            hs, os_only, no_en, dbl_only;
  logic [CW_W-1:0] diff;

  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  always_comb begin
    hs       = in_valid && out_ready;
    diff     = out_cw ^ in_cw;
    no_en    = !(ctl_q[B_CS] || ctl_q[B_OS] || ctl_q[B_CD] || ctl_q[B_OD]);
    os_only  = ctl_q[B_OS] && !ctl_q[B_CS] && !ctl_q[B_CD] && !ctl_q[B_OD];
    dbl_only = (ctl_q[B_CD] || ctl_q[B_OD]) && !ctl_q[B_CS] && !ctl_q[B_OS];
  end

  AST_STREAM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(out_valid && !out_ready && !reg_we) && out_valid && $stable(in_cw))
    |-> $stable(out_cw)); // R1

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    no_en |-> (diff == '0)); // R2

  AST_ONESHOT_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(hs && (diff != '0) && os_only && !reg_we) && os_only && hs)
    |-> (diff == '0)); // R5

  AST_DOUBLE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(diff) == 2) |-> diff[CW_W-1]); // R7

  AST_RANGE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(ctl_q[POS_W-1:0]) >= CW_W) ||
     (dbl_only && (32'(ctl_q[POS_W-1:0]) == CW_W - 1))) |-> (diff == '0)); // R8

  AST_WEIGHT_MAX2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(diff) <= 2); // R10
endmodule

bind ecc_wr_injector inj_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_cw     (in_cw),
  .out_cw    (out_cw),
  .ctl_q     (ctl_q)
);

// File: tb/tb_ecc_wr_injector.sv
module tb_ecc_wr_injector;
  localparam int CLK_P = 10;
  localparam int CW    = 72;
  localparam logic [10:0] CS = 11'h080, OS = 11'h100, CD = 11'h200, OD = 11'h400;

  logic          clk = 0, rst_n = 0, reg_we = 0, in_valid = 0, out_ready = 0;
  logic [10:0]   reg_wdata = '0;
  logic [CW-1:0] in_cw = '0;
  logic          in_ready, out_valid;
  logic [CW-1:0] out_cw;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ecc_wr_injector dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_cw(in_cw),
    .out_valid(out_valid), .out_ready(out_ready), .out_cw(out_cw)
  );

  function automatic logic [6:0] dcode(int i);
    int n = 0;
    for (int c = 3; c < 128; c++)
      if ((c & (c - 1)) != 0) begin
        if (n == i) return 7'(c);
        n++;
      end
    return '0;
  endfunction

  function automatic logic [CW-1:0] encode(logic [63:0] d);
    logic [CW-1:0] w = '0;
    logic [6:0] s = '0;
    w[63:0] = d;
    for (int i = 0; i < 64; i++) if (d[i]) s ^= dcode(i);
    w[70:64] = s;
    w[71] = ^w[70:0];
    return w;
  endfunction

  // 0 clean, 1 correctable, 2 uncorrectable
  function automatic int classify(logic [CW-1:0] w);
    logic [6:0] s = '0;
    for (int i = 0; i < 64; i++) if (w[i]) s ^= dcode(i);
    for (int j = 0; j < 7; j++) if (w[64+j]) s ^= 7'(1 << j);
    if (^w) return 1;
    return (s == 0) ? 0 : 2;
  endfunction

  function automatic logic [CW-1:0] bitm(int p);
    logic [CW-1:0] m = '0;
    if (p >= 0 && p < CW) m[p] = 1'b1;
    return m;
  endfunction

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_cls(string tag, logic [CW-1:0] w, int exp);
    int a = classify(w);
    checks++;
    if (a != exp) begin
      failures++;
      $display("FAIL %s class act=%0d exp=%0d", tag, a, exp);
    end
  endtask

  task automatic reg_wr(logic [10:0] v);
    @(negedge clk); reg_we = 1; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wr_word(string tag, logic [63:0] d, logic [CW-1:0] m, int cls);
    logic [CW-1:0] c = encode(d);
    @(negedge clk); in_valid = 1; out_ready = 1; in_cw = c;
    #1;
    check(tag, out_cw, c ^ m);
    check_cls(tag, out_cw, cls);
    @(negedge clk); in_valid = 0;
  endtask

  function automatic logic [63:0] pat(int p);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(p + 1);
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] m, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1/R2/R3 reset state: no injection, stream links follow
    @(negedge clk); in_valid = 1; out_ready = 0; in_cw = encode(pat(7));
    #1;
    check("R1 out_valid", {71'b0, out_valid}, {71'b0, 1'b1});
    check("R1 in_ready", {71'b0, in_ready}, '0);
    check("R3 reset pass", out_cw, encode(pat(7)));
    @(negedge clk); in_valid = 0;
    wr_word("R2 idle pass", pat(3), '0, 0);

    // R4 continuous single over every position
    for (int p = 0; p < 80; p++) begin
      reg_wr(CS | 11'(p));
      for (int k = 0; k < 2; k++)
        wr_word("R4 cont single", pat(p + k), bitm(p), (p < CW) ? 1 : 0);
    end
    reg_wr('0);

    // R5/R6/R8 one-shot single: fire once, stay spent, rearm via 0
    for (int p = 0; p < 80; p++) begin
      reg_wr(OS | 11'(p));
      wr_word("R5 once first", pat(p), bitm(p), (p < CW) ? 1 : 0);
      wr_word("R5 once after", pat(p + 1), '0, 0);
      reg_wr(OS | 11'(p));
      wr_word("R6 rewrite one no rearm", pat(p + 2), '0, (p < CW) ? 0 : 0);
      reg_wr('0);
      reg_wr(OS | 11'(p));
      wr_word("R6 rearm", pat(p + 3), bitm(p), (p < CW) ? 1 : 0);
      reg_wr('0);
    end
    // R8 inert one-shot is not consumed
    reg_wr(OS | 11'd100);
    wr_word("R8 inert once", pat(1), '0, 0);
    reg_wr(OS | 11'd12);
    wr_word("R8 not consumed", pat(2), bitm(12), 1);
    reg_wr('0);

    // R7/R8 double, continuous and one-shot
    for (int p = 0; p < 80; p++) begin
      m = (p < CW - 1) ? (bitm(p) | bitm(CW - 1)) : '0;
      reg_wr(CD | 11'(p));
      wr_word("R7 cont double a", pat(p), m, (p < CW - 1) ? 2 : 0);
      wr_word("R7 cont double b", pat(p + 5), m, (p < CW - 1) ? 2 : 0);
      reg_wr('0);
      reg_wr(OD | 11'(p));
      wr_word("R7 once double", pat(p), m, (p < CW - 1) ? 2 : 0);
      wr_word("R7 once double after", pat(p + 1), '0, 0);
      reg_wr('0);
    end

    // R9 priority
    reg_wr(CD | OD | CS | OS | 11'd5);
    wr_word("R9 cd wins", pat(1), bitm(5) | bitm(71), 2);
    reg_wr(OD | CS | OS | 11'd5);
    wr_word("R9 od not consumed under cd", pat(2), bitm(5) | bitm(71), 2);
    wr_word("R9 cs after od spent", pat(3), bitm(5), 1);
    reg_wr(OD | OS | 11'd5);
    wr_word("R9 os fires", pat(4), bitm(5), 1);
    wr_word("R9 all spent", pat(5), '0, 0);
    reg_wr('0);
    reg_wr(CS | OS | 11'd71);
    wr_word("R9 cs over os", pat(6), bitm(71), 1);
    reg_wr(OS | 11'd71);
    wr_word("R9 os unconsumed", pat(7), bitm(71), 1);
    reg_wr('0);

    // R1 back-pressure: stalled word holds, one-shot spent only on accept
    reg_wr(OS | 11'd9);
    c = encode(pat(40));
    @(negedge clk); in_valid = 1; out_ready = 0; in_cw = c;
    #1; check("R1 stall in_ready", {71'b0, in_ready}, '0);
    check("R1 stall flipped", out_cw, c ^ bitm(9));
    repeat (3) @(negedge clk);
    #1; check("R1 stall hold", out_cw, c ^ bitm(9));
    out_ready = 1;
    #1; check("R1 accept flipped", out_cw, c ^ bitm(9));
    @(negedge clk); in_valid = 0;
    wr_word("R1 spent after accept", pat(41), '0, 0);
    reg_wr('0);

    // R3 write effect from the next cycle
    c = encode(pat(50));
    @(negedge clk); reg_we = 1; reg_wdata = CS | 11'd3;
    in_valid = 1; out_ready = 1; in_cw = c;
    #1; check("R3 same cycle old ctl", out_cw, c);
    @(negedge clk); reg_we = 0;
    #1; check("R3 next cycle new ctl", out_cw, c ^ bitm(3));
    @(negedge clk); in_valid = 0;
    reg_wr('0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule